// File: doc/BRIEF.md
# I2C Master Byte-Transfer Controller

This block is a single-master I2C controller that software drives through three 32-bit registers: control, data buffer and status. Each byte on the bus is one command. Software places a byte in the data buffer and then writes the control register with the transfer trigger set. The same write can also request a START before the byte, a STOP after its acknowledge bit, or a NACK in place of ACK when the byte is received. A separate abort command sends a STOP with no data transfer.

SCL and SDA are driven open-drain: the block only pulls a line low or releases it, and reads SDA back. Completion and error events go into sticky status bits that software clears by writing 1. The low status nibble shows live state and is not affected by writes. The SCL rate comes from a parameterised quarter-period divider. Every SCL bit cell takes four quarters, and only one line changes per quarter.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both line drivers are released, the control and status registers read 0, and the data buffer reads 0.
- R2: A control write with transfer (bit 0) and START (bit 1) issues a START or repeated START, then shifts out the data buffer MSB first as the address byte. Data bit 0 sets the read/write mode (status bit 0: 1 = read) for the following bytes. Bus-busy (status bit 3) rises at the START.
- R3: A transfer without START, in write mode, shifts the data buffer out MSB first. When the acknowledge bit completes, transmit-empty (status bit 4) latches.
- R4: A transfer in read mode shifts in 8 bits MSB first and then places them in the data buffer, setting receive-full (status bit 5). The block drives ACK (SDA low) unless NACK (control bit 3) was set, in which case it releases SDA. Status bit 1 shows the sampled acknowledge level (1 = NACK).
- R5: When STOP (control bit 2) accompanies a transfer, a STOP condition follows that byte's acknowledge. Bus-busy then clears and both lines are released.
- R6: A control write with abort (bit 4) and transfer clear sends a STOP without any data bits. Bus-busy clears at its end.
- R7: If SDA reads high in the acknowledge slot after a transmitted byte, bus-error (status bit 7) latches.
- R8: If SDA reads low while the block is releasing it during a transmitted data bit, arbitration-lost (status bit 6) latches. Both lines are released in the same cycle, the transfer bit clears, bus-busy and unit-busy (status bit 2) clear, and no transmit-empty is set.
- R9: Writing 1 to status bits 7:4 clears them and writing 0 leaves them. Writes do not alter status bits 3:0.
- R10: Control bit 0 reads 1 while a transfer is in progress and clears itself when the byte and its acknowledge are done. Writes to the data buffer (register 1) while it is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write select: 0 control, 1 data buffer, 2 status |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 2 | Read select, same map |
| reg_rd_data | output | 32 | Read data (combinational) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Level of the SDA line |

## Verification
The bench builds the block with a quarter-period divider of 4, so each SCL bit takes 16 clocks and a whole address, read and write sequence fits in a few thousand cycles. With that divider, a behavioural target on the wired-AND bus can follow every edge. It acknowledges one address, captures written bytes and returns counting read data. Through that target the bench reaches an address NACK, a NACK on the last read, a repeated STOP through abort, and arbitration loss forced by pulling SDA low during the first address bit.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

    localparam int REG_W = 32;
    localparam int BYTE_W = 8;
    localparam int BITS_PER_BYTE = BYTE_W + 1;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int C_XFER  = 0;
    localparam int C_START = 1;
    localparam int C_STOP  = 2;
    localparam int C_NACK  = 3;
    localparam int C_ABORT = 4;

    localparam int N_EVT = 4;
    localparam int EVT_LSB = 4;

    typedef enum logic [2:0] {
        E_IDLE,
        E_HOLD,
        E_START,
        E_BIT,
        E_STOP
    } eng_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic nack;
        logic abort;
    } cmd_t;

    typedef struct packed {
        logic berr;
        logic al;
        logic rxf;
        logic txe;
    } evt_t;

    typedef struct packed {
        logic bus_busy;
        logic unit_busy;
        logic ack;
        logic rd_mode;
    } live_t;

    function automatic logic [REG_W-1:0] stat_word(logic [N_EVT-1:0] lat, live_t lv);
        return {{(REG_W-N_EVT-4){1'b0}}, lat, lv};
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(logic xfer, cmd_t q);
        return {{(REG_W-4){1'b0}}, q.nack, q.stop, q.start, xfer};
    endfunction

endpackage

// File: rtl/i2c_bm_clkgen.sv
module i2c_bm_clkgen #(
    parameter int QDIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= (cnt_q == LAST);
            cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    initial begin
        assert (QDIV >= 2) else $error("quarter divider too small");
    end
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
    import i2c_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cmd_go,
    input  cmd_t              cmd,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output evt_t              ev_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output live_t             live_o
);
    localparam int BCW = $clog2(BITS_PER_BYTE);
    localparam logic [BCW-1:0] ACK_SLOT = BCW'(BYTE_W);

    eng_state_t        st_q;
    logic [1:0]        qtr_q;
    logic [BCW-1:0]    bcnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic [BYTE_W-1:0] rx_q;
    logic              dir_rd_q, mode_rd_q, stop_after_q, nack_after_q;
    logic              scl_low_q, sda_low_q, bus_busy_q, ack_q;
    evt_t              ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= E_IDLE;
            qtr_q        <= '0;
            bcnt_q       <= '0;
            sh_q         <= '0;
            rx_q         <= '0;
            dir_rd_q     <= 1'b0;
            mode_rd_q    <= 1'b0;
            stop_after_q <= 1'b0;
            nack_after_q <= 1'b0;
            scl_low_q    <= 1'b0;
            sda_low_q    <= 1'b0;
            bus_busy_q   <= 1'b0;
            ack_q        <= 1'b0;
            ev_q         <= '0;
        end else begin
            ev_q <= '0;
            if (cmd_go) begin
                qtr_q  <= '0;
                bcnt_q <= '0;
                if (cmd.abort) begin
                    st_q <= E_STOP;
                end else begin
                    sh_q         <= tx_byte;
                    stop_after_q <= cmd.stop;
                    nack_after_q <= cmd.nack;
                    if (cmd.start) begin
                        mode_rd_q <= tx_byte[0];
                        dir_rd_q  <= 1'b0;
                        st_q      <= E_START;
                    end else begin
                        dir_rd_q <= mode_rd_q;
                        st_q     <= E_BIT;
                    end
                end
            end else if (tick) begin
                qtr_q <= qtr_q + 2'd1;
                case (st_q)
                    E_HOLD: sda_low_q <= 1'b0;
                    E_START: begin
                        case (qtr_q)
                            2'd0: sda_low_q <= 1'b0;
                            2'd1: scl_low_q <= 1'b0;
                            2'd2: begin
                                sda_low_q  <= 1'b1;
                                bus_busy_q <= 1'b1;
                            end
                            default: begin
                                scl_low_q <= 1'b1;
                                st_q      <= E_BIT;
                            end
                        endcase
                    end
                    E_BIT: begin
                        case (qtr_q)
                            2'd0: begin
                                if (bcnt_q == ACK_SLOT)
                                    sda_low_q <= dir_rd_q & ~nack_after_q;
                                else
                                    sda_low_q <= ~dir_rd_q & ~sh_q[BYTE_W-1];
                            end
                            2'd1: scl_low_q <= 1'b0;
                            2'd2: begin
                                if (bcnt_q != ACK_SLOT) begin
                                    if (!dir_rd_q && !sda_low_q && !sda_i) begin
                                        st_q       <= E_IDLE;
                                        scl_low_q  <= 1'b0;
                                        sda_low_q  <= 1'b0;
                                        bus_busy_q <= 1'b0;
                                        ev_q.al    <= 1'b1;
                                    end else begin
                                        sh_q <= {sh_q[BYTE_W-2:0], sda_i};
                                    end
                                end else begin
                                    ack_q <= sda_i;
                                    if (!dir_rd_q && sda_i)
                                        ev_q.berr <= 1'b1;
                                end
                            end
                            default: begin
                                scl_low_q <= 1'b1;
                                if (bcnt_q != ACK_SLOT) begin
                                    bcnt_q <= bcnt_q + 1'b1;
                                end else begin
                                    bcnt_q <= '0;
                                    if (dir_rd_q) begin
                                        ev_q.rxf <= 1'b1;
                                        rx_q     <= sh_q;
                                    end else begin
                                        ev_q.txe <= 1'b1;
                                    end
                                    st_q <= stop_after_q ? E_STOP : E_HOLD;
                                end
                            end
                        endcase
                    end
                    E_STOP: begin
                        case (qtr_q)
                            2'd0: scl_low_q <= 1'b1;
                            2'd1: sda_low_q <= 1'b1;
                            2'd2: scl_low_q <= 1'b0;
                            default: begin
                                sda_low_q  <= 1'b0;
                                bus_busy_q <= 1'b0;
                                st_q       <= E_IDLE;
                            end
                        endcase
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_low_o = scl_low_q;
    assign sda_low_o = sda_low_q;
    assign ev_o      = ev_q;
    assign rx_byte_o = rx_q;

    always_comb begin
        live_o.bus_busy  = bus_busy_q;
        live_o.unit_busy = (st_q != E_IDLE) && (st_q != E_HOLD);
        live_o.ack       = ack_q;
        live_o.rd_mode   = mode_rd_q;
    end

    // R8: arbitration loss leaves both lines released and the sequencer idle
    p_al_release_r8: assert property (@(posedge clk) disable iff (rst)
        ev_q.al |-> (!scl_low_q && !sda_low_q && st_q == E_IDLE && !bus_busy_q));

    // R5: the bus is never declared free while a line is still pulled low
    p_stop_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy_q) |-> (!scl_low_q && !sda_low_q));

    // R7: a bus error is only flagged together with a NACK level
    p_berr_nack_r7: assert property (@(posedge clk) disable iff (rst)
        ev_q.berr |-> ack_q);

    // R3: one byte ends either as transmitted or as received, never both
    p_txe_rxf_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_q.txe, ev_q.rxf, ev_q.al}));

    // R2: SDA only changes while SCL is held low, except for START/STOP edges
    p_sda_while_low_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == E_BIT && !$stable(sda_low_q) && !ev_q.al) |-> $past(scl_low_q));
endmodule

// File: rtl/i2c_bm_regs.sv
module i2c_bm_regs
    import i2c_bm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  evt_t              ev_i,
    input  logic [BYTE_W-1:0] rx_byte_i,
    input  live_t             live_i,
    output logic              cmd_go_o,
    output cmd_t              cmd_o,
    output logic [BYTE_W-1:0] tx_byte_o
);
    logic              xfer_q;
    cmd_t              qual_q;
    logic [BYTE_W-1:0] dbuf_q;
    logic [N_EVT-1:0]  lat_q;
    logic [N_EVT-1:0]  ev_vec;
    logic              ctrl_wr, data_wr, stat_wr, byte_done;

    assign ev_vec    = ev_i;
    assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
    assign data_wr   = wr_en && (wr_addr == A_DATA);
    assign stat_wr   = wr_en && (wr_addr == A_STAT);
    assign byte_done = ev_i.txe | ev_i.rxf | ev_i.al;

    assign cmd_go_o = ctrl_wr && !live_i.unit_busy &&
                      (wr_data[C_XFER] || wr_data[C_ABORT]);

    always_comb begin
        cmd_o.start = wr_data[C_XFER] & wr_data[C_START];
        cmd_o.stop  = wr_data[C_XFER] & wr_data[C_STOP];
        cmd_o.nack  = wr_data[C_XFER] & wr_data[C_NACK];
        cmd_o.abort = ~wr_data[C_XFER] & wr_data[C_ABORT];
    end
    assign tx_byte_o = dbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q <= 1'b0;
            qual_q <= '0;
            dbuf_q <= '0;
        end else begin
            if (cmd_go_o) begin
                qual_q <= cmd_o;
                xfer_q <= wr_data[C_XFER];
            end else if (byte_done) begin
                xfer_q <= 1'b0;
            end
            if (ev_i.rxf)
                dbuf_q <= rx_byte_i;
            else if (data_wr && !xfer_q)
                dbuf_q <= wr_data[BYTE_W-1:0];
        end
    end

    for (genvar gi = 0; gi < N_EVT; gi++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst)
                lat_q[gi] <= 1'b0;
            else if (ev_vec[gi])
                lat_q[gi] <= 1'b1;
            else if (stat_wr && wr_data[EVT_LSB+gi])
                lat_q[gi] <= 1'b0;
        end

        // R9: a write of 1 to a sticky bit with no new event clears it
        p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
            (stat_wr && wr_data[EVT_LSB+gi] && !ev_vec[gi]) |=> !lat_q[gi]);
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = ctrl_word(xfer_q, qual_q);
            A_DATA:  rd_data = {{(REG_W-BYTE_W){1'b0}}, dbuf_q};
            A_STAT:  rd_data = stat_word(lat_q, live_i);
            default: rd_data = '0;
        endcase
    end

    // R10: the data buffer holds while a transfer owns it
    p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (data_wr && xfer_q && !ev_i.rxf) |=> $stable(dbuf_q));

    // R10: transfer bit drops once the byte is finished
    p_xfer_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (byte_done && !cmd_go_o) |=> !xfer_q);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2c_bm_pkg::*;
#(
    parameter int QDIV = 125
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr_en,
    input  logic [1:0]       reg_wr_addr,
    input  logic [REG_W-1:0] reg_wr_data,
    input  logic [1:0]       reg_rd_addr,
    output logic [REG_W-1:0] reg_rd_data,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    input  logic             sda_i
);
    logic              tick;
    logic              cmd_go;
    cmd_t              cmd;
    logic [BYTE_W-1:0] tx_byte, rx_byte;
    evt_t              ev;
    live_t             live;

    i2c_bm_clkgen #(.QDIV(QDIV)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    i2c_bm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data),
        .rd_addr   (reg_rd_addr),
        .rd_data   (reg_rd_data),
        .ev_i      (ev),
        .rx_byte_i (rx_byte),
        .live_i    (live),
        .cmd_go_o  (cmd_go),
        .cmd_o     (cmd),
        .tx_byte_o (tx_byte)
    );

    i2c_bm_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmd_go    (cmd_go),
        .cmd       (cmd),
        .tx_byte   (tx_byte),
        .sda_i     (sda_i),
        .scl_low_o (scl_oe_o),
        .sda_low_o (sda_oe_o),
        .ev_o      (ev),
        .rx_byte_o (rx_byte),
        .live_o    (live)
    );
endmodule

// File: tb/i2c_byte_master_bench.sv
`timescale 1ns/1ps
module i2c_byte_master_bench;
    localparam logic [6:0] TGT = 7'h50;
    localparam logic [7:0] RD_FIRST = 8'hC3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        scl_oe, sda_oe;
    logic        force_low = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done_flag = 0;

    // target model state
    logic       s_drive = 1'b0;
    logic       s_active = 1'b0, s_addr_ph = 1'b0, s_read = 1'b0, s_sel = 1'b0;
    logic       s_mack = 1'b1;
    int         s_cnt = 0;
    logic [7:0] s_shift = 8'h00, s_tx = 8'h00, s_wbyte = 8'h00;

    wire scl_w = ~scl_oe;
    wire sda_w = ~(sda_oe | s_drive | force_low);

    always #10 clk = ~clk;

    i2c_byte_master #(.QDIV(4)) u_i2c_byte_master (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (wr_en),
        .reg_wr_addr (wr_addr),
        .reg_wr_data (wr_data),
        .reg_rd_addr (rd_addr),
        .reg_rd_data (rd_data),
        .scl_oe_o    (scl_oe),
        .sda_oe_o    (sda_oe),
        .sda_i       (sda_w)
    );

    always @(negedge sda_w) if (scl_w) begin
        s_active = 1'b1; s_cnt = 0; s_addr_ph = 1'b1; s_drive = 1'b0;
    end
    always @(posedge sda_w) if (scl_w) begin
        s_active = 1'b0; s_drive = 1'b0;
    end
    always @(posedge scl_w) if (s_active) begin
        if (s_cnt < 8) begin
            s_shift = {s_shift[6:0], sda_w};
            s_cnt = s_cnt + 1;
        end else if (s_cnt == 8) begin
            s_mack = sda_w;
            s_cnt = 9;
        end
    end
    always @(negedge scl_w) if (s_active) begin
        if (s_cnt == 8) begin
            if (s_addr_ph) begin
                s_sel = (s_shift[7:1] == TGT);
                s_read = s_shift[0];
                s_drive = s_sel;
            end else if (!s_read) begin
                s_wbyte = s_shift;
                s_drive = s_sel;
            end else begin
                s_drive = 1'b0;
            end
        end else if (s_cnt == 9) begin
            s_cnt = 0;
            if (s_addr_ph) begin
                s_addr_ph = 1'b0;
                if (s_read && s_sel) begin
                    s_tx = RD_FIRST;
                    s_drive = ~s_tx[7];
                end else s_drive = 1'b0;
            end else if (s_read && s_sel && !s_mack) begin
                s_tx = s_tx + 8'd1;
                s_drive = ~s_tx[7];
            end else s_drive = 1'b0;
        end else if (!s_addr_ph && s_read && s_sel && s_cnt >= 1 && s_cnt <= 7) begin
            s_drive = ~s_tx[7-s_cnt];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            reg_rd(2'd2, s);
            if (!s[2]) return;
        end
        check("wait", 32'd1, 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_rd(2'd2, v); check("R1 status", v, 32'h0);
        reg_rd(2'd0, v); check("R1 control", v, 32'h0);
        reg_rd(2'd1, v); check("R1 data", v, 32'h0);
        check("R1 lines", {30'd0, scl_oe, sda_oe}, 32'h0);
    endtask

    task automatic t_addr_write();
        logic [31:0] v;
        reg_wr(2'd1, 32'h0000_00A0);
        reg_wr(2'd0, 32'h3);
        reg_rd(2'd0, v); check("R10 xfer set", v[0], 1'b1);
        reg_wr(2'd1, 32'h0000_0055);
        wait_idle();
        reg_rd(2'd1, v); check("R10 data write ignored", v, 32'hA0);
        reg_rd(2'd0, v); check("R10 xfer clear", v[0], 1'b0);
        reg_rd(2'd2, v); check("R2 addr status", v, 32'h18);
        check("R2 target selected", {31'd0, s_sel}, 32'd1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        reg_wr(2'd2, 32'h0000_000F);
        reg_rd(2'd2, v); check("R9 zero write keeps", v, 32'h18);
        reg_wr(2'd2, 32'h0000_0010);
        reg_rd(2'd2, v); check("R9 one write clears", v, 32'h08);
    endtask

    task automatic t_write_stop();
        logic [31:0] v;
        reg_wr(2'd1, 32'h0000_003C);
        reg_wr(2'd0, 32'h5);
        wait_idle();
        check("R3 byte delivered", {24'd0, s_wbyte}, 32'h3C);
        reg_rd(2'd2, v); check("R5 stop status", v, 32'h10);
        check("R5 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
        check("R5 target saw stop", {31'd0, s_active}, 32'd0);
        reg_wr(2'd2, 32'hF0);
    endtask

    task automatic t_read();
        logic [31:0] v;
        reg_wr(2'd1, 32'h0000_00A1);
        reg_wr(2'd0, 32'h3);
        wait_idle();
        reg_rd(2'd2, v); check("R2 read mode status", v, 32'h19);
        reg_wr(2'd2, 32'hF0);
        reg_wr(2'd0, 32'h1);
        wait_idle();
        reg_rd(2'd1, v); check("R4 first read byte", v, {24'd0, RD_FIRST});
        reg_rd(2'd2, v); check("R4 ack status", v, 32'h29);
        reg_wr(2'd2, 32'hF0);
        reg_wr(2'd0, 32'hD);
        wait_idle();
        reg_rd(2'd1, v); check("R4 second read byte", v, {24'd0, RD_FIRST + 8'd1});
        reg_rd(2'd2, v); check("R4 nack stop status", v, 32'h23);
        reg_wr(2'd2, 32'hF0);
    endtask

    task automatic t_berr_abort();
        logic [31:0] v;
        reg_wr(2'd1, 32'h0000_0022);
        reg_wr(2'd0, 32'h3);
        wait_idle();
        reg_rd(2'd2, v); check("R7 bus error status", v, 32'h9A);
        reg_wr(2'd0, 32'h10);
        wait_idle();
        reg_rd(2'd2, v); check("R6 abort status", v, 32'h92);
        check("R6 target saw stop", {31'd0, s_active}, 32'd0);
        check("R6 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
        reg_wr(2'd2, 32'hF0);
    endtask

    task automatic t_arb();
        logic [31:0] v;
        force_low = 1'b1;
        reg_wr(2'd1, 32'h0000_00A0);
        reg_wr(2'd0, 32'h3);
        wait_idle();
        reg_rd(2'd2, v); check("R8 arbitration status", v & 32'hFC, 32'h40);
        reg_rd(2'd0, v); check("R8 xfer cleared", v[0], 1'b0);
        check("R8 lines released", {30'd0, scl_oe, sda_oe}, 32'h0);
        force_low = 1'b0;
        reg_wr(2'd2, 32'hF0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_addr_write();
        t_w1c();
        t_write_stop();
        t_read();
        t_berr_abort();
        t_arb();
        repeat (10) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule